// File: doc/BRIEF.md
# Drive-to-Pack Load Table

This block holds the mapping between eight emulated disk drives and the packs loaded on them. A pack is a contiguous run of blocks on one of two removable storage cards. It is described by the card it lives on, its first block and its length in blocks. A disk controller translates every drive-relative block number through this table. Commands load or unload packs. Slot events track which cards are physically present.

Taking a card out of its slot unloads, in the same clock, every drive whose pack lives on that card. A drive with nothing loaded shows its ready flag low. A lookup on such a drive returns a not-loaded fault instead of an address. A lookup past the end of a loaded pack returns a range fault.

The table can start out populated. While reset is held, a preset image on dedicated inputs is captured, so a system can run straight after power-up without a loading phase.

Top module: `pack_load_table`

## Requirements
- R1: While `rst_n` is low, each drive takes its card, start and size from the preset inputs. It is loaded only if its preset-loaded bit is 1 and `init_present` marks its card as present. The slot presence takes `init_present`. `lk_done`, both fault flags and `cmd_err` are 0.
- R2: `drive_ready[d]` is 1 exactly when drive d holds a loaded pack. It reflects commands and slot events from the previous clock.
- R3: A lookup (`lk_valid`) is answered one clock later with `lk_done`=1. On success, `lk_card` is the pack's card and `lk_addr` = (pack start + `lk_block`) modulo 2^BLK_W.
- R4: A lookup with `lk_block` greater than or equal to the pack size sets `lk_range_fault`, with `lk_card` and `lk_addr` at 0. A pack of size 0 faults on every block.
- R5: A lookup on a drive with no pack loaded sets `lk_nl_fault` and not `lk_range_fault`, with `lk_card` and `lk_addr` at 0.
- R6: A load command (`cmd_valid`=1, `cmd_unload`=0) to a present card stores the card, start and size for `cmd_drive` and marks it loaded. It replaces any mapping the drive already had.
- R7: A load to a card that is not present leaves the table unchanged. It raises `cmd_err` for exactly one clock, one clock after the command.
- R8: An unload command (`cmd_unload`=1) clears the drive's loaded state and never raises `cmd_err`. Unloading an empty drive changes nothing.
- R9: A pulse on `slot_remove[c]` marks slot c absent. It unloads every drive whose pack is on card c.
- R10: A removal takes priority over a lookup or a load in the same clock. A lookup on a drive whose card is being removed returns the not-loaded fault. A load to the card being removed is rejected as in R7.
- R11: `slot_insert[c]` marks slot c present, and a removal in the same clock wins. A load in the same clock as its card's insertion is accepted.
- R12: A lookup in the same clock as a load or unload of the same drive uses the mapping held before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; preset image captured while low |
| init_loaded | input | NUM_DRIVES | Preset loaded bit per drive |
| init_card | input | NUM_DRIVES*SLOT_W | Preset card per drive, drive d at bits d*SLOT_W upward |
| init_start | input | NUM_DRIVES*BLK_W | Preset start block per drive, drive d at bits d*BLK_W upward |
| init_size | input | NUM_DRIVES*BLK_W | Preset size per drive, same packing |
| init_present | input | NUM_SLOTS | Preset slot presence |
| slot_insert | input | NUM_SLOTS | Card-inserted pulse per slot |
| slot_remove | input | NUM_SLOTS | Card-removed pulse per slot |
| cmd_valid | input | 1 | Command strobe |
| cmd_unload | input | 1 | 1 = unload, 0 = load |
| cmd_drive | input | DRV_W | Target drive |
| cmd_card | input | SLOT_W | Card holding the pack (load only) |
| cmd_start | input | BLK_W | First block of the pack (load only) |
| cmd_size | input | BLK_W | Pack length in blocks (load only) |
| cmd_err | output | 1 | Load rejected because the card is absent |
| lk_valid | input | 1 | Lookup strobe |
| lk_drive | input | DRV_W | Drive to translate |
| lk_block | input | BLK_W | Drive-relative block |
| lk_done | output | 1 | Lookup answer valid |
| lk_nl_fault | output | 1 | Drive had no pack loaded |
| lk_range_fault | output | 1 | Block beyond pack end |
| lk_card | output | SLOT_W | Physical card of the answer |
| lk_addr | output | BLK_W | Physical block of the answer |
| drive_ready | output | NUM_DRIVES | Per-drive ready flag |

## Verification
A card removal can land in the same clock as a lookup or a load aimed at that card. Slot insert and remove can also coincide with each other. The bench issues these in single clocks: a removal together with a lookup on a drive mapped to that card, a removal together with a load to it, and insert together with remove on one slot. The reference model applies the removal before the lookup and the load. Its answer, fault flags, error flag and ready vector are compared with the design's on the following clock.

// File: rtl/pack_load_table.sv
module pack_load_table #(
  parameter int NUM_DRIVES = 8,
  parameter int NUM_SLOTS  = 2,
  parameter int BLK_W      = 24,
  localparam int DRV_W     = $clog2(NUM_DRIVES),
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_DRIVES-1:0]       init_loaded,
  input  logic [NUM_DRIVES*SLOT_W-1:0] init_card,
  input  logic [NUM_DRIVES*BLK_W-1:0] init_start,
  input  logic [NUM_DRIVES*BLK_W-1:0] init_size,
  input  logic [NUM_SLOTS-1:0]        init_present,
  input  logic [NUM_SLOTS-1:0]        slot_insert,
  input  logic [NUM_SLOTS-1:0]        slot_remove,
  input  logic                        cmd_valid,
  input  logic                        cmd_unload,
  input  logic [DRV_W-1:0]            cmd_drive,
  input  logic [SLOT_W-1:0]           cmd_card,
  input  logic [BLK_W-1:0]            cmd_start,
  input  logic [BLK_W-1:0]            cmd_size,
  output logic                        cmd_err,
  input  logic                        lk_valid,
  input  logic [DRV_W-1:0]            lk_drive,
  input  logic [BLK_W-1:0]            lk_block,
  output logic                        lk_done,
  output logic                        lk_nl_fault,
  output logic                        lk_range_fault,
  output logic [SLOT_W-1:0]           lk_card,
  output logic [BLK_W-1:0]            lk_addr,
  output logic [NUM_DRIVES-1:0]       drive_ready
);

  localparam int SLOT_SPAN = 1 << SLOT_W;

  logic [NUM_DRIVES-1:0] loaded;
  logic [SLOT_W-1:0]     card_q  [NUM_DRIVES];
  logic [BLK_W-1:0]      start_q [NUM_DRIVES];
  logic [BLK_W-1:0]      size_q  [NUM_DRIVES];
  logic [NUM_SLOTS-1:0]  present;
  logic [NUM_SLOTS-1:0]  present_nxt;
  logic [SLOT_SPAN-1:0]  pres_pad, rem_pad, ipres_pad;

  assign present_nxt = (present | slot_insert) & ~slot_remove;
  assign pres_pad    = SLOT_SPAN'(present_nxt);
  assign rem_pad     = SLOT_SPAN'(slot_remove);
  assign ipres_pad   = SLOT_SPAN'(init_present);

  wire load_req = cmd_valid & ~cmd_unload;
  wire load_go  = load_req & pres_pad[cmd_card];
  wire drop_req = cmd_valid & cmd_unload;

  always_ff @(posedge clk) begin
    if (!rst_n) present <= init_present;
    else        present <= present_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DRIVES; d++) begin
        card_q[d]  <= init_card[d*SLOT_W +: SLOT_W];
        start_q[d] <= init_start[d*BLK_W +: BLK_W];
        size_q[d]  <= init_size[d*BLK_W +: BLK_W];
        loaded[d]  <= init_loaded[d] & ipres_pad[init_card[d*SLOT_W +: SLOT_W]];
      end
    end else begin
      for (int d = 0; d < NUM_DRIVES; d++) begin
        if (load_go && cmd_drive == DRV_W'(d)) begin
          loaded[d]  <= 1'b1;
          card_q[d]  <= cmd_card;
          start_q[d] <= cmd_start;
          size_q[d]  <= cmd_size;
        end else if ((drop_req && cmd_drive == DRV_W'(d)) || rem_pad[card_q[d]]) begin
          loaded[d]  <= 1'b0;
        end
      end
    end
  end

  wire [SLOT_W-1:0] lk_c    = card_q[lk_drive];
  wire              lk_live = loaded[lk_drive] & ~rem_pad[lk_c];
  wire              lk_inr  = lk_block < size_q[lk_drive];
  wire              lk_ok   = lk_valid & lk_live & lk_inr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done        <= 1'b0;
      lk_nl_fault    <= 1'b0;
      lk_range_fault <= 1'b0;
      lk_card        <= '0;
      lk_addr        <= '0;
      cmd_err        <= 1'b0;
    end else begin
      lk_done        <= lk_valid;
      lk_nl_fault    <= lk_valid & ~lk_live;
      lk_range_fault <= lk_valid & lk_live & ~lk_inr;
      lk_card        <= lk_ok ? lk_c : '0;
      lk_addr        <= lk_ok ? start_q[lk_drive] + lk_block : '0;
      cmd_err        <= load_req & ~pres_pad[cmd_card];
    end
  end

  assign drive_ready = loaded;

endmodule

// File: rtl/pack_load_table_chk.sv
module pack_load_table_chk #(
  parameter int NUM_DRIVES = 8,
  parameter int NUM_SLOTS  = 2,
  parameter int BLK_W      = 24,
  localparam int DRV_W     = $clog2(NUM_DRIVES),
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_SLOTS-1:0]  slot_remove,
  input logic                  cmd_valid,
  input logic                  cmd_unload,
  input logic [DRV_W-1:0]      cmd_drive,
  input logic                  cmd_err,
  input logic                  lk_valid,
  input logic [DRV_W-1:0]      lk_drive,
  input logic                  lk_done,
  input logic                  lk_nl_fault,
  input logic                  lk_range_fault,
  input logic [SLOT_W-1:0]     lk_card,
  input logic [BLK_W-1:0]      lk_addr,
  input logic [NUM_DRIVES-1:0] drive_ready
);

  a_r3_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_done);

  a_r3_no_stray_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_done);

  a_r5_unready_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !drive_ready[lk_drive]) |=> (lk_nl_fault && !lk_range_fault));

  a_r4_fault_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_nl_fault || lk_range_fault) |-> (lk_done && lk_card == '0 && lk_addr == '0));

  a_r7_err_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && !cmd_unload));

  a_r8_unload_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_unload) |=> (!drive_ready[$past(cmd_drive)] && !cmd_err));

  a_r9_all_removed: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_remove) |=> (drive_ready == '0));

endmodule

bind pack_load_table pack_load_table_chk #(
  .NUM_DRIVES(NUM_DRIVES), .NUM_SLOTS(NUM_SLOTS), .BLK_W(BLK_W)
) u_chk (.*);

// File: tb/pack_load_table_bench.sv
`timescale 1ns/1ps
module pack_load_table_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]    init_loaded;
  logic [7:0]    init_card;
  logic [191:0]  init_start, init_size;
  logic [1:0]    init_present;
  logic [1:0]    slot_insert, slot_remove;
  logic          cmd_valid, cmd_unload;
  logic [2:0]    cmd_drive;
  logic          cmd_card;
  logic [23:0]   cmd_start, cmd_size;
  logic          cmd_err;
  logic          lk_valid;
  logic [2:0]    lk_drive;
  logic [23:0]   lk_block;
  logic          lk_done, lk_nl_fault, lk_range_fault;
  logic          lk_card;
  logic [23:0]   lk_addr;
  logic [7:0]    drive_ready;

  always #2.5 clk = ~clk;

  pack_load_table u_pack_load_table (.*);

  int n_chk = 0, n_err = 0;
  bit chk_on = 0, finished = 0;
  string phase = "R1";

  int m_ld[8], m_card[8], m_start[8], m_size[8];
  bit m_pres[2];
  bit e_done, e_nl, e_rng, e_err;
  int e_card, e_addr;

  always @(posedge clk) begin
    bit pn[2];
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) m_pres[c] = init_present[c];
      for (int d = 0; d < 8; d++) begin
        m_card[d]  = init_card[d];
        m_start[d] = init_start[d*24 +: 24];
        m_size[d]  = init_size[d*24 +: 24];
        m_ld[d]    = init_loaded[d] && m_pres[m_card[d]];
      end
      e_done = 0; e_nl = 0; e_rng = 0; e_err = 0; e_card = 0; e_addr = 0;
    end else begin
      for (int c = 0; c < 2; c++) pn[c] = (m_pres[c] || slot_insert[c]) && !slot_remove[c];
      e_done = lk_valid; e_nl = 0; e_rng = 0; e_card = 0; e_addr = 0;
      if (lk_valid) begin
        if (!m_ld[lk_drive] || slot_remove[m_card[lk_drive]]) e_nl = 1;
        else if (int'(lk_block) >= m_size[lk_drive]) e_rng = 1;
        else begin
          e_card = m_card[lk_drive];
          e_addr = (m_start[lk_drive] + int'(lk_block)) & 32'h00FF_FFFF;
        end
      end
      for (int d = 0; d < 8; d++) if (slot_remove[m_card[d]]) m_ld[d] = 0;
      e_err = 0;
      if (cmd_valid) begin
        if (cmd_unload) m_ld[cmd_drive] = 0;
        else if (pn[cmd_card]) begin
          m_ld[cmd_drive] = 1; m_card[cmd_drive] = cmd_card;
          m_start[cmd_drive] = cmd_start; m_size[cmd_drive] = cmd_size;
        end else e_err = 1;
      end
      for (int c = 0; c < 2; c++) m_pres[c] = pn[c];
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      logic [7:0] er;
      for (int d = 0; d < 8; d++) er[d] = m_ld[d] != 0;
      chk(drive_ready === er, "ready", drive_ready, er);
      chk(lk_done === e_done, "done", lk_done, e_done);
      chk(cmd_err === e_err, "cmd_err", cmd_err, e_err);
      if (e_done) begin
        chk(lk_nl_fault === e_nl, "nl_fault", lk_nl_fault, e_nl);
        chk(lk_range_fault === e_rng, "range_fault", lk_range_fault, e_rng);
        chk(lk_card === 1'(e_card), "card", lk_card, e_card);
        chk(lk_addr === 24'(e_addr), "addr", lk_addr, e_addr);
      end
    end
  end

  task automatic idle();
    slot_insert = 0; slot_remove = 0; cmd_valid = 0; cmd_unload = 0;
    cmd_drive = 0; cmd_card = 0; cmd_start = 0; cmd_size = 0;
    lk_valid = 0; lk_drive = 0; lk_block = 0;
  endtask
  task automatic tick(); @(negedge clk); idle(); endtask
  task automatic lookup(input int d, input int b);
    lk_valid = 1; lk_drive = 3'(d); lk_block = 24'(b); tick();
  endtask
  task automatic load(input int d, input int c, input int s, input int z);
    cmd_valid = 1; cmd_drive = 3'(d); cmd_card = 1'(c); cmd_start = 24'(s); cmd_size = 24'(z); tick();
  endtask
  task automatic unload(input int d);
    cmd_valid = 1; cmd_unload = 1; cmd_drive = 3'(d); tick();
  endtask
  task automatic do_reset(input logic [1:0] pres);
    chk_on = 0; init_present = pres; rst_n = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1; chk_on = 1;
  endtask

  initial begin
    init_loaded = 8'b0000_1111;
    init_card   = 8'b0000_0110;
    init_start  = '0; init_size = '0;
    init_start[0*24 +: 24] = 24'd100;  init_size[0*24 +: 24] = 24'd50;
    init_start[1*24 +: 24] = 24'd2000; init_size[1*24 +: 24] = 24'd10;
    init_start[2*24 +: 24] = 24'd5000; init_size[2*24 +: 24] = 24'd8;
    init_start[3*24 +: 24] = 24'd7;    init_size[3*24 +: 24] = 24'd0;
    phase = "R1"; do_reset(2'b11); tick();
    phase = "R3"; lookup(0, 0); lookup(0, 49); lookup(1, 3); lookup(2, 7); tick();
    phase = "R4"; lookup(0, 50); lookup(1, 10); lookup(3, 0); tick();
    phase = "R5"; lookup(5, 0); lookup(7, 1); tick();
    phase = "R6"; load(5, 1, 24'hFFFFF0, 40); lookup(5, 32'h20); lookup(5, 39);
    load(0, 1, 300, 5); lookup(0, 4); lookup(0, 5); tick();
    phase = "R12"; lk_valid = 1; lk_drive = 0; lk_block = 1;
    cmd_valid = 1; cmd_drive = 0; cmd_card = 0; cmd_start = 900; cmd_size = 3; tick();
    lookup(0, 1);
    lk_valid = 1; lk_drive = 0; lk_block = 2; cmd_valid = 1; cmd_unload = 1; cmd_drive = 0; tick();
    lookup(0, 2); load(0, 0, 100, 50); tick();
    phase = "R8"; unload(5); lookup(5, 0); unload(5); unload(6); tick();
    phase = "R9"; slot_remove = 2'b10; tick(); lookup(1, 0); lookup(2, 0); lookup(0, 0);
    phase = "R7"; load(4, 1, 10, 10); lookup(4, 0); tick();
    phase = "R11"; slot_insert = 2'b10; cmd_valid = 1; cmd_drive = 4; cmd_card = 1;
    cmd_start = 77; cmd_size = 4; tick(); lookup(4, 3);
    slot_insert = 2'b01; slot_remove = 2'b01; tick(); load(6, 0, 1, 1); lookup(6, 0);
    slot_insert = 2'b01; tick(); load(6, 0, 1, 1); lookup(6, 0);
    phase = "R10"; slot_remove = 2'b01; lk_valid = 1; lk_drive = 6; lk_block = 0; tick();
    lookup(6, 0);
    slot_insert = 2'b01; tick(); load(7, 0, 55, 9);
    slot_remove = 2'b01; cmd_valid = 1; cmd_drive = 3; cmd_card = 0; cmd_start = 1; cmd_size = 2;
    lk_valid = 1; lk_drive = 7; lk_block = 2; tick(); lookup(3, 1); lookup(7, 2);
    slot_remove = 2'b11; tick(); tick();
    phase = "R2"; slot_insert = 2'b11; tick();
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 8) slot_remove = 2'($urandom_range(1, 3));
      if (r > 80) slot_insert = 2'($urandom_range(1, 3));
      if (r % 3 == 0) begin
        cmd_valid = 1; cmd_unload = ($urandom_range(0, 4) == 0);
        cmd_drive = 3'($urandom); cmd_card = 1'($urandom);
        cmd_start = 24'($urandom); cmd_size = 24'($urandom_range(0, 40));
      end
      if (r % 2 == 0) begin
        lk_valid = 1; lk_drive = 3'($urandom); lk_block = 24'($urandom_range(0, 45));
      end
      tick();
    end
    tick();
    phase = "R1"; do_reset(2'b01); tick(); lookup(1, 0); lookup(0, 1); tick();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL %s watchdog: actual=running expected=finished", phase);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule